// File: doc/BRIEF.md
# Interrupt Acknowledge and Reset Sequencer

This block is the part of a small CPU's control logic that answers outside events. A peripheral asks for service by pulsing a request line high for one clock. The block holds that request until the execution core says it is ready. It then raises an acknowledge line for exactly two clock cycles. The first of those cycles moves no data. At the clock edge that ends the second cycle, the block samples the 8-bit peripheral bus and presents that byte as the interrupt vector, together with a one-cycle valid strobe.

The block also watches the CPU reset pin. The pin counts only if it is high at a rising clock edge. Each edge that finds it high makes the block emit, in the next cycle, a load-PC strobe whose target is the reset vector 0xFFFE. A reset pin held high for several edges gives one strobe per edge. Reset wins over any interrupt activity: it aborts an acknowledge in flight and throws away any held request.

Top module: `irq_ack_reset_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycles that follow its release, `ack_o`, `vec_valid_o` and `pc_load_o` are 0, and `vec_byte_o` and `pc_target_o` are zero.
- R2: Suppose that at a rising edge the request is asserted, the core is ready, the sequencer is idle and the reset pin is low. Then `ack_o` is high in the two cycles after that edge, and low in the cycle after those two.
- R3: A request sampled while the core is not ready is held. The acknowledge starts at the first later edge at which `core_ready_i` is high. The held request is cleared when the acknowledge starts, so one pulse produces exactly one acknowledge.
- R4: No vector is delivered during the first acknowledge cycle. `io_data_i` is sampled at the edge that ends the second acknowledge cycle. In the cycle that follows, `vec_valid_o` is high for one cycle, `ack_o` is low, and `vec_byte_o` holds the sampled byte. `vec_byte_o` keeps that value until the next capture.
- R5: A request that arrives while an acknowledge is in progress is held. With the core ready, it starts a new acknowledge at the edge after the one that ends the current acknowledge, leaving exactly one idle cycle between the two.
- R6: For each rising edge at which `reset_pin_i` is high, `pc_load_o` is high in the next cycle with `pc_target_o` = 0xFFFE. With the pin high for N consecutive edges, `pc_load_o` is high for N consecutive cycles. When `pc_load_o` is low, `pc_target_o` is zero.
- R7: A high level on `reset_pin_i` that starts and ends between two rising edges has no effect.
- R8: When `reset_pin_i` is high at an edge during an acknowledge, `ack_o` is low in the next cycle, no vector is delivered for that acknowledge, and any held request is discarded.
- R9: A request sampled at an edge where `reset_pin_i` is high is ignored: it is neither acknowledged nor held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously inside the block |
| reset_pin_i | input | 1 | CPU reset pin, sampled at each rising edge |
| irq_i | input | 1 | Interrupt request pulse from a peripheral |
| core_ready_i | input | 1 | High when the core can accept an interrupt |
| io_data_i | input | DATA_W (8) | Peripheral bus, carries the vector byte |
| ack_o | output | 1 | Interrupt acknowledge line |
| vec_valid_o | output | 1 | One-cycle strobe: a vector byte was captured |
| vec_byte_o | output | DATA_W (8) | Most recently captured vector byte |
| pc_load_o | output | 1 | Strobe telling the core to load its program counter |
| pc_target_o | output | ADDR_W (16) | Program counter target: the reset vector while `pc_load_o` is high |

## Verification
The assertions assume that every input changes synchronously to `clk`, with a level that is stable around each rising edge. They also assume that the peripheral drives the vector byte during the second acknowledge cycle. The bench meets both conditions. It changes every input only at falling edges. The single exception is the deliberate short reset-pin glitch, which rises and falls within one low phase of the clock. It places the vector byte on the bus only for the edge that ends the second acknowledge cycle, and a different byte at every other edge, so a capture at the wrong edge shows up as a wrong byte. Sweeps over the core-ready delay, the arrival time of a second request, the reset-pin hold length and the point at which reset aborts the handshake stay within these assumptions.

// File: rtl/iars_pkg.sv
package iars_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_QUIET = 2'd1,
    ACK_XFER  = 2'd2
  } ack_state_e;
endpackage

// File: rtl/iars_rst_sync.sv
module iars_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shreg_q <= '0;
    else         shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
  end

  assign srst_n_o = shreg_q[STAGES-1];
endmodule

// File: rtl/iars_req_latch.sv
module iars_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_hit_i,
  input  logic irq_i,
  input  logic take_i,
  output logic request_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q | irq_i;
    if (take_i)      pend_d = 1'b0;
    if (reset_hit_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign request_o = pend_q | irq_i;
endmodule

// File: rtl/iars_ack_fsm.sv
module iars_ack_fsm
  import iars_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic reset_hit_i,
  input  logic request_i,
  input  logic ready_i,
  output logic ack_o,
  output logic take_o,
  output logic xfer_o
);
  ack_state_e state_q, state_d;
  logic       start;

  assign start = (state_q == ACK_IDLE) && request_i && ready_i && !reset_hit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE:  if (start) state_d = ACK_QUIET;
      ACK_QUIET: state_d = ACK_XFER;
      ACK_XFER:  state_d = ACK_IDLE;
      default:   state_d = ACK_IDLE;
    endcase
    if (reset_hit_i) state_d = ACK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACK_IDLE;
    else        state_q <= state_d;
  end

  assign ack_o  = (state_q != ACK_IDLE);
  assign take_o = start;
  assign xfer_o = (state_q == ACK_XFER) && !reset_hit_i;
endmodule

// File: rtl/iars_vec_cap.sv
module iars_vec_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] byte_o
);
  logic              vld_q;
  logic [DATA_W-1:0] byte_q, byte_d;

  always_comb begin
    byte_d = byte_q;
    if (xfer_i) byte_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q  <= xfer_i;
      byte_q <= byte_d;
    end
  end

  assign valid_o = vld_q;
  assign byte_o  = byte_q;
endmodule

// File: rtl/iars_rst_seq.sv
module iars_rst_seq #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_hit_i,
  output logic              load_o,
  output logic [ADDR_W-1:0] target_o
);
  logic load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= reset_hit_i;
  end

  assign load_o   = load_q;
  assign target_o = load_q ? RESET_VEC : '0;
endmodule

// File: rtl/irq_ack_reset_seq.sv
module irq_ack_reset_seq #(
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC  = 16'hFFFE,
  parameter int                SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_pin_i,
  input  logic              irq_i,
  input  logic              core_ready_i,
  input  logic [DATA_W-1:0] io_data_i,
  output logic              ack_o,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_byte_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_target_o
);
  logic core_rst_n;
  logic request, take, xfer;

  iars_rst_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (core_rst_n)
  );

  iars_req_latch u_req (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .reset_hit_i (reset_pin_i),
    .irq_i       (irq_i),
    .take_i      (take),
    .request_o   (request)
  );

  iars_ack_fsm u_fsm (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .reset_hit_i (reset_pin_i),
    .request_i   (request),
    .ready_i     (core_ready_i),
    .ack_o       (ack_o),
    .take_o      (take),
    .xfer_o      (xfer)
  );

  iars_vec_cap #(.DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .xfer_i  (xfer),
    .data_i  (io_data_i),
    .valid_o (vec_valid_o),
    .byte_o  (vec_byte_o)
  );

  iars_rst_seq #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_rst (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .reset_hit_i (reset_pin_i),
    .load_o      (pc_load_o),
    .target_o    (pc_target_o)
  );
endmodule

// File: rtl/iars_chk.sv
module iars_chk #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC    = 16'hFFFE
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              reset_pin_i,
  input logic              ack_o,
  input logic              vec_valid_o,
  input logic              pc_load_o,
  input logic [ADDR_W-1:0] pc_target_o
);
  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(ack_o) && !reset_pin_i |=> ack_o);

  // R2
  ack_len_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ack_o && $past(ack_o) |=> !ack_o);

  // R4
  vec_after_two_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    vec_valid_o |-> !ack_o && $past(ack_o) && $past(ack_o, 2));

  // R6
  pc_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    reset_pin_i |=> pc_load_o && (pc_target_o == VEC));

  // R6
  pc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !reset_pin_i |=> !pc_load_o);

  // R8
  reset_abort_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    reset_pin_i |=> !ack_o && !vec_valid_o);
endmodule

bind irq_ack_reset_seq iars_chk #(.ADDR_W(ADDR_W), .VEC(RESET_VEC)) u_chk (
  .clk         (clk),
  .rst_ok      (core_rst_n),
  .reset_pin_i (reset_pin_i),
  .ack_o       (ack_o),
  .vec_valid_o (vec_valid_o),
  .pc_load_o   (pc_load_o),
  .pc_target_o (pc_target_o)
);

// File: tb/irq_ack_reset_seq_tb.sv
module irq_ack_reset_seq_tb;
  logic        clk;
  logic        rst_n;
  logic        reset_pin_i;
  logic        irq_i;
  logic        core_ready_i;
  logic [7:0]  io_data_i;
  logic        ack_o;
  logic        vec_valid_o;
  logic [7:0]  vec_byte_o;
  logic        pc_load_o;
  logic [15:0] pc_target_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_ack_reset_seq u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_pin_i  (reset_pin_i),
    .irq_i        (irq_i),
    .core_ready_i (core_ready_i),
    .io_data_i    (io_data_i),
    .ack_o        (ack_o),
    .vec_valid_o  (vec_valid_o),
    .vec_byte_o   (vec_byte_o),
    .pc_load_o    (pc_load_o),
    .pc_target_o  (pc_target_o)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic expect_eq(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic quiet(input int n);
    irq_i = 0; core_ready_i = 0; reset_pin_i = 0; io_data_i = 8'h00;
    repeat (n) @(negedge clk);
  endtask

  // R2 R3 R4: ready arrives d edges after the request pulse
  task automatic sweep_ready(input int d);
    logic [7:0] v;
    v = 8'(d * 37 + 5);
    for (int t = 0; t <= d + 4; t++) begin
      irq_i        = (t == 0);
      core_ready_i = (t >= d);
      io_data_i    = (t == d + 2) ? v : ~v;
      @(negedge clk);
      expect_eq($sformatf("R2/R3 ack d=%0d t=%0d", d, t), 16'(ack_o), 16'((t == d) || (t == d + 1)));
      expect_eq($sformatf("R4 valid d=%0d t=%0d", d, t), 16'(vec_valid_o), 16'(t == d + 2));
      if (t >= d + 2)
        expect_eq($sformatf("R4 byte d=%0d t=%0d", d, t), 16'(vec_byte_o), 16'(v));
    end
    quiet(2);
  endtask

  // R5: second request at edge j during or right after the first acknowledge
  task automatic sweep_second(input int j);
    logic [7:0] v1, v2;
    v1 = 8'(8'h30 + j);
    v2 = 8'(8'hC0 + j);
    for (int t = 0; t <= 7; t++) begin
      irq_i        = (t == 0) || (t == j);
      core_ready_i = 1;
      io_data_i    = (t == 2) ? v1 : (t == 5) ? v2 : 8'h5A;
      @(negedge clk);
      expect_eq($sformatf("R5 ack j=%0d t=%0d", j, t), 16'(ack_o),
                16'((t == 0) || (t == 1) || (t == 3) || (t == 4)));
      expect_eq($sformatf("R5 valid j=%0d t=%0d", j, t), 16'(vec_valid_o), 16'((t == 2) || (t == 5)));
      if (t == 2) expect_eq($sformatf("R5 byte1 j=%0d", j), 16'(vec_byte_o), 16'(v1));
      if (t == 5) expect_eq($sformatf("R5 byte2 j=%0d", j), 16'(vec_byte_o), 16'(v2));
    end
    quiet(2);
  endtask

  // R6: reset pin held for h edges
  task automatic sweep_hold(input int h);
    for (int t = 0; t <= h + 1; t++) begin
      reset_pin_i = (t < h);
      @(negedge clk);
      expect_eq($sformatf("R6 load h=%0d t=%0d", h, t), 16'(pc_load_o), 16'(t < h));
      expect_eq($sformatf("R6 target h=%0d t=%0d", h, t), pc_target_o, (t < h) ? 16'hFFFE : 16'h0000);
    end
    quiet(1);
  endtask

  // R8 R9: reset at edge a aborts the acknowledge; request at edge 1 is dropped
  task automatic sweep_abort(input int a);
    for (int t = 0; t <= 7; t++) begin
      irq_i        = (t == 0) || (t == 1);
      core_ready_i = 1;
      reset_pin_i  = (t == a);
      io_data_i    = 8'h77;
      @(negedge clk);
      expect_eq($sformatf("R8 ack a=%0d t=%0d", a, t), 16'(ack_o), 16'(t < a));
      expect_eq($sformatf("R8 valid a=%0d t=%0d", a, t), 16'(vec_valid_o), 16'(0));
      expect_eq($sformatf("R8 load a=%0d t=%0d", a, t), 16'(pc_load_o), 16'(t == a));
    end
    quiet(2);
  endtask

  initial begin
    rst_n = 0;
    reset_pin_i = 0; irq_i = 0; core_ready_i = 0; io_data_i = 8'h00;
    repeat (3) @(negedge clk);
    expect_eq("R1 ack in reset", 16'(ack_o), 16'(0));
    expect_eq("R1 valid in reset", 16'(vec_valid_o), 16'(0));
    expect_eq("R1 load in reset", 16'(pc_load_o), 16'(0));
    rst_n = 1;
    repeat (4) @(negedge clk);
    expect_eq("R1 ack", 16'(ack_o), 16'(0));
    expect_eq("R1 valid", 16'(vec_valid_o), 16'(0));
    expect_eq("R1 byte", 16'(vec_byte_o), 16'(0));
    expect_eq("R1 load", 16'(pc_load_o), 16'(0));
    expect_eq("R1 target", pc_target_o, 16'h0000);

    for (int d = 0; d <= 5; d++) sweep_ready(d);
    for (int j = 1; j <= 3; j++) sweep_second(j);
    for (int h = 1; h <= 5; h++) sweep_hold(h);
    for (int a = 1; a <= 2; a++) sweep_abort(a);

    // R7: glitch on the reset pin inside one low phase
    #4 reset_pin_i = 1;
    #2 reset_pin_i = 0;
    @(negedge clk);
    expect_eq("R7 glitch load", 16'(pc_load_o), 16'(0));
    expect_eq("R7 glitch target", pc_target_o, 16'h0000);

    // R9: request sampled together with reset, core not ready, then ready
    irq_i = 1; reset_pin_i = 1; core_ready_i = 0;
    @(negedge clk);
    irq_i = 0; reset_pin_i = 0; core_ready_i = 1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      expect_eq($sformatf("R9 ack t=%0d", t), 16'(ack_o), 16'(0));
    end
    quiet(1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule